// File: doc/BRIEF.md
# Operand-Size and Legality Decoder

This block sits in an instruction decode path, after prefix detection and before operand fetch. Each cycle that a strobe is presented, it receives three prefix flags (a 64-bit operand-width prefix bit, an operand-size override bit and an address-size override bit), the primary opcode byte and a mode bit that says whether the core runs in 64-bit mode. It sorts the opcode into one of three size behaviours: promotable, default-64 or fixed byte-width. From that class it works out the effective operand size and the effective address size.

It also reports whether pointer and count registers have to be zero-extended to 64 bits. It produces the mask that applies to shift and rotate counts, and it flags the decimal-adjust opcodes as illegal in 64-bit mode. All results are captured in an output register stage and appear one cycle after the strobe, together with a valid bit.

Top module: `opsz_decoder`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `dec_valid` high. When `dec_valid` is low, all result outputs keep their previous values.
- R2: In 64-bit mode the opcodes 37h, 3Fh, D4h and D5h raise `bad_opcode`. In legacy mode `bad_opcode` is never raised.
- R3: Size codes are 00 = 8 bits, 01 = 16 bits, 10 = 32 bits and 11 = 64 bits. For a promotable opcode in 64-bit mode, `pfx_wide` gives 64 bits even if `pfx_opsz` is also present. Without `pfx_wide`, `pfx_opsz` gives 16 bits, and with neither prefix the size is 32 bits.
- R4: The default-64 opcodes are 50h–5Fh, 68h, 6Ah, 70h–7Fh, 8Fh, 9Ch, 9Dh, C2h, C3h, C9h, E0h–E3h, E8h, E9h and EBh. In 64-bit mode they give 64 bits, or 16 bits when `pfx_opsz` is present. `pfx_wide` has no effect on them, and they never give 32 bits.
- R5: The fixed byte-width opcodes are B0h–B7h, A8h, every opcode below 40h whose low three bits are 100b, and 37h, 3Fh, D4h and D5h. In either mode they report 8 bits whatever prefixes are present.
- R6: In legacy mode `pfx_wide` is ignored. Every opcode that is not fixed byte-width gives 32 bits, or 16 bits when `pfx_opsz` is present.
- R7: In 64-bit mode the address size is 64 bits, or 32 bits when `pfx_adsz` is present. `ptr_zext` is high exactly when the address size is 32 bits.
- R8: In legacy mode the address size is 32 bits, or 16 bits when `pfx_adsz` is present, and `ptr_zext` is low.
- R9: `cnt_mask` is 3Fh when the reported operand size is 64 bits and 1Fh otherwise.
- R10: While reset is asserted and after it, until the first strobe, `res_valid`, `bad_opcode` and `ptr_zext` are low, and the size codes and `cnt_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Input strobe; loads the result register |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| pfx_wide | input | 1 | 64-bit operand-width prefix bit present |
| pfx_opsz | input | 1 | Operand-size override prefix present |
| pfx_adsz | input | 1 | Address-size override prefix present |
| opcode | input | 8 | Primary opcode byte |
| res_valid | output | 1 | Results valid (one cycle after strobe) |
| op_size | output | 2 | Effective operand size code |
| addr_size | output | 2 | Effective address size code |
| ptr_zext | output | 1 | Pointer/count registers zero-extended to 64 bits |
| bad_opcode | output | 1 | Opcode illegal in current mode |
| cnt_mask | output | 6 | Shift/rotate count mask |

## Verification
The assertions assume that the mode bit, the prefix flags and the opcode are stable and known in any cycle where `dec_valid` is high. They also assume that the prefix flags describe a single instruction, so any combination of the three may appear together. The stimulus changes inputs only on the falling edge and draws every prefix combination, both modes and opcodes from the whole byte range. Directed vectors add each class boundary, the four illegal opcodes and the case where both operand prefixes are present, so that every class meets every prefix pattern.

// File: rtl/opsz_pkg.sv
package opsz_pkg;
  localparam int OPC_W = 8;
  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    CLS_PROMO  = 2'b00,
    CLS_DEF64  = 2'b01,
    CLS_FIXED8 = 2'b10,
    CLS_DECADJ = 2'b11
  } opclass_e;

  typedef struct packed {
    logic wide;
    logic opsz;
    logic adsz;
  } pfx_t;
endpackage

// File: rtl/opsz_classify.sv
module opsz_classify
  import opsz_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opc,
  output opclass_e      cls
);
  localparam int HI = OW - 1;

  logic [OW-1:0] op8;
  assign op8 = opc;

  always_comb begin
    cls = CLS_PROMO;
    if (op8 == 8'h37 || op8 == 8'h3F || op8 == 8'hD4 || op8 == 8'hD5) begin
      cls = CLS_DECADJ;
    end else if ((op8[HI:HI-1] == 2'b00 && op8[2:0] == 3'b100) ||
                 (op8[HI:3] == 5'b10110) || op8 == 8'hA8) begin
      cls = CLS_FIXED8;
    end else if (op8[HI:4] == 4'h5 || op8[HI:4] == 4'h7 ||
                 (op8[HI:2] == 6'b111000)) begin
      cls = CLS_DEF64;
    end else begin
      case (op8)
        8'h68, 8'h6A, 8'h8F, 8'h9C, 8'h9D,
        8'hC2, 8'hC3, 8'hC9, 8'hE8, 8'hE9, 8'hEB: cls = CLS_DEF64;
        default:                                  cls = CLS_PROMO;
      endcase
    end
  end
endmodule

// File: rtl/opsz_opsize.sv
module opsz_opsize
  import opsz_pkg::*;
(
  input  opclass_e cls,
  input  logic     lm,
  input  pfx_t     pfx,
  output size_e    osz,
  output logic     illegal
);
  always_comb begin
    illegal = lm && (cls == CLS_DECADJ);
    osz     = SZ_32;
    unique case (cls)
      CLS_FIXED8, CLS_DECADJ: osz = SZ_8;
      CLS_DEF64: begin
        if (!lm)           osz = pfx.opsz ? SZ_16 : SZ_32;
        else if (pfx.opsz) osz = SZ_16;
        else               osz = SZ_64;
      end
      default: begin
        if (lm && pfx.wide) osz = SZ_64;
        else if (pfx.opsz)  osz = SZ_16;
        else                osz = SZ_32;
      end
    endcase
  end
endmodule

// File: rtl/opsz_adsize.sv
module opsz_adsize
  import opsz_pkg::*;
(
  input  logic  lm,
  input  logic  adsz_ovr,
  output size_e asz,
  output logic  zext
);
  always_comb begin
    if (lm) begin
      asz  = adsz_ovr ? SZ_32 : SZ_64;
      zext = adsz_ovr;
    end else begin
      asz  = adsz_ovr ? SZ_16 : SZ_32;
      zext = 1'b0;
    end
  end
endmodule

// File: rtl/opsz_decoder.sv
module opsz_decoder
  import opsz_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic          long_mode,
  input  logic          pfx_wide,
  input  logic          pfx_opsz,
  input  logic          pfx_adsz,
  input  logic [OW-1:0] opcode,
  output logic          res_valid,
  output logic [1:0]    op_size,
  output logic [1:0]    addr_size,
  output logic          ptr_zext,
  output logic          bad_opcode,
  output logic [CW-1:0] cnt_mask
);
  localparam logic [CW-1:0] MASK_WIDE   = {CW{1'b1}};
  localparam logic [CW-1:0] MASK_NARROW = {1'b0, {(CW-1){1'b1}}};

  pfx_t     pfx;
  opclass_e cls;
  size_e    osz_c, asz_c;
  logic     ill_c, zext_c;
  logic [CW-1:0] mask_c;

  logic          vld_d, vld_q;
  logic [1:0]    osz_d, osz_q, asz_d, asz_q;
  logic          zext_d, zext_q, ill_d, ill_q;
  logic [CW-1:0] mask_d, mask_q;

  assign pfx = '{wide: pfx_wide, opsz: pfx_opsz, adsz: pfx_adsz};

  opsz_classify #(.OW(OW)) u_cls (.opc(opcode), .cls(cls));
  opsz_opsize u_osz (.cls(cls), .lm(long_mode), .pfx(pfx), .osz(osz_c), .illegal(ill_c));
  opsz_adsize u_asz (.lm(long_mode), .adsz_ovr(pfx.adsz), .asz(asz_c), .zext(zext_c));

  assign mask_c = (osz_c == SZ_64) ? MASK_WIDE : MASK_NARROW;

  // next-state
  always_comb begin
    vld_d  = dec_valid;
    osz_d  = osz_q;
    asz_d  = asz_q;
    zext_d = zext_q;
    ill_d  = ill_q;
    mask_d = mask_q;
    if (dec_valid) begin
      osz_d  = osz_c;
      asz_d  = asz_c;
      zext_d = zext_c;
      ill_d  = ill_c;
      mask_d = mask_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      osz_q  <= 2'b00;
      asz_q  <= 2'b00;
      zext_q <= 1'b0;
      ill_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      vld_q  <= vld_d;
      osz_q  <= osz_d;
      asz_q  <= asz_d;
      zext_q <= zext_d;
      ill_q  <= ill_d;
      mask_q <= mask_d;
    end
  end

  assign res_valid  = vld_q;
  assign op_size    = osz_q;
  assign addr_size  = asz_q;
  assign ptr_zext   = zext_q;
  assign bad_opcode = ill_q;
  assign cnt_mask   = mask_q;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> res_valid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !res_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(op_size) && $stable(addr_size) && $stable(bad_opcode)));
  a_r2_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && long_mode && (opcode == 8'h37 || opcode == 8'hD4)) |=> bad_opcode);
  a_r2_legacy_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !long_mode) |=> (!bad_opcode && !ptr_zext && op_size != 2'b11));
  a_r4_never32: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && long_mode && cls == CLS_DEF64) |=> op_size != 2'b10);
  a_r7_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && long_mode && pfx_adsz) |=> (ptr_zext && addr_size == 2'b10));
  a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cnt_mask == ((op_size == 2'b11) ? 6'h3F : 6'h1F)));
endmodule

// File: tb/test_opsz_decoder.sv
module test_opsz_decoder;
  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, long_mode, pfx_wide, pfx_opsz, pfx_adsz;
  logic [7:0] opcode;
  logic res_valid, ptr_zext, bad_opcode;
  logic [1:0] op_size, addr_size;
  logic [5:0] cnt_mask;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opsz_decoder i_opsz_decoder (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .long_mode(long_mode),
    .pfx_wide(pfx_wide), .pfx_opsz(pfx_opsz), .pfx_adsz(pfx_adsz), .opcode(opcode),
    .res_valid(res_valid), .op_size(op_size), .addr_size(addr_size),
    .ptr_zext(ptr_zext), .bad_opcode(bad_opcode), .cnt_mask(cnt_mask));

  // 0 promotable, 1 default-64, 2 byte fixed, 3 decimal adjust
  function automatic int kind(input logic [7:0] o);
    if (o == 8'h37 || o == 8'h3F || o == 8'hD4 || o == 8'hD5) return 3;
    if ((o < 8'h40 && o[2:0] == 3'd4) || (o >= 8'hB0 && o <= 8'hB7) || o == 8'hA8) return 2;
    if ((o >= 8'h50 && o <= 8'h5F) || (o >= 8'h70 && o <= 8'h7F) ||
        (o >= 8'hE0 && o <= 8'hE3)) return 1;
    if (o == 8'h68 || o == 8'h6A || o == 8'h8F || o == 8'h9C || o == 8'h9D ||
        o == 8'hC2 || o == 8'hC3 || o == 8'hC9 || o == 8'hE8 || o == 8'hE9 ||
        o == 8'hEB) return 1;
    return 0;
  endfunction

  function automatic logic [1:0] exp_os(input logic lm, w, p, input logic [7:0] o);
    int k = kind(o);
    if (k >= 2) return 2'b00;
    if (!lm) return p ? 2'b01 : 2'b10;
    if (k == 1) return p ? 2'b01 : 2'b11;
    if (w) return 2'b11;
    return p ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic lm, w, p, a, input logic [7:0] o);
    logic [1:0] eo;
    @(negedge clk);
    dec_valid = 1'b1; long_mode = lm; pfx_wide = w; pfx_opsz = p; pfx_adsz = a; opcode = o;
    @(negedge clk);
    dec_valid = 1'b0;
    eo = exp_os(lm, w, p, o);
    chk("R1 valid", {7'd0, res_valid}, 8'd1);
    if (kind(o) >= 2) chk("R5 fixed size", {6'd0, op_size}, {6'd0, eo});
    else if (!lm)     chk("R6 legacy size", {6'd0, op_size}, {6'd0, eo});
    else if (kind(o) == 1) chk("R4 default64 size", {6'd0, op_size}, {6'd0, eo});
    else              chk("R3 promotable size", {6'd0, op_size}, {6'd0, eo});
    chk("R2 invalid", {7'd0, bad_opcode}, {7'd0, (lm && kind(o) == 3)});
    if (lm) begin
      chk("R7 addr size", {6'd0, addr_size}, a ? 8'd2 : 8'd3);
      chk("R7 zext", {7'd0, ptr_zext}, {7'd0, a});
    end else begin
      chk("R8 addr size", {6'd0, addr_size}, a ? 8'd1 : 8'd2);
      chk("R8 zext", {7'd0, ptr_zext}, 8'd0);
    end
    chk("R9 count mask", {2'd0, cnt_mask}, (eo == 2'b11) ? 8'h3F : 8'h1F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [1:0] so, sa;
    logic sz, sb;
    void'($urandom(32'd1357));
    rst_n = 1'b0; dec_valid = 1'b0; long_mode = 1'b0;
    pfx_wide = 1'b0; pfx_opsz = 1'b0; pfx_adsz = 1'b0; opcode = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {7'd0, res_valid}, 8'd0);
    chk("R10 reset sizes", {4'd0, op_size, addr_size}, 8'd0);
    chk("R10 reset flags", {5'd0, ptr_zext, bad_opcode, 1'b0}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {res_valid, cnt_mask, bad_opcode}, 8'd0);

    // directed corners
    apply(1, 0, 0, 0, 8'h37); apply(1, 1, 1, 1, 8'h3F);
    apply(1, 0, 0, 0, 8'hD4); apply(1, 0, 1, 0, 8'hD5);
    apply(0, 1, 1, 0, 8'h37); apply(0, 0, 0, 1, 8'hD5);
    apply(1, 1, 1, 0, 8'h01); apply(1, 0, 1, 0, 8'h01); apply(1, 0, 0, 1, 8'h01);
    apply(1, 1, 0, 0, 8'h50); apply(1, 1, 1, 0, 8'hE8); apply(1, 0, 0, 0, 8'hE3);
    apply(1, 1, 0, 0, 8'hE4); apply(1, 1, 0, 0, 8'h4F); apply(1, 1, 1, 0, 8'hCB);
    apply(1, 1, 1, 1, 8'hB7); apply(1, 1, 1, 1, 8'hB8); apply(0, 1, 0, 0, 8'h3C);
    apply(0, 1, 0, 0, 8'h50); apply(0, 1, 1, 1, 8'h89);

    // R1 hold: no strobe, changed inputs, outputs unchanged
    so = op_size; sa = addr_size; sz = ptr_zext; sb = bad_opcode;
    @(negedge clk);
    long_mode = 1'b1; pfx_wide = 1'b1; opcode = 8'h37; pfx_adsz = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", {7'd0, res_valid}, 8'd0);
    chk("R1 hold", {2'd0, op_size, addr_size, sz, sb}, {2'd0, so, sa, ptr_zext, bad_opcode});

    for (int i = 0; i < 800; i++) begin
      apply(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule